// File: doc/BRIEF.md
# Dual-Source SRAM Write Arbiter

This block lives in the clock domain of a synchronous SRAM that has no bus turnaround latency. It collects write requests from two first-word-fall-through FIFOs. The FIFOs are filled from two unrelated clock domains and are read in this one. Each FIFO's empty flag arrives already synchronised to the SRAM clock. While the flag is low, the FIFO's head word is visible on the FIFO's address and data outputs. A read-enable pulse pops that word on the next rising edge.

The arbiter decides which FIFO to serve by looking at nothing but the two empty flags. It registers a one-hot select that doubles as the FIFO read enable. On the next cycle it drives the popped word's address onto the SRAM together with a one-cycle write strobe. The matching data word travels down a short valid-tagged shift pipeline and is driven, with its output enable, two cycles after the address.

A FIFO's empty flag is still low in the cycle straight after its read pulse, even when that pulse took the last word. The arbiter therefore never reads the same FIFO in that cycle. When both FIFOs are ready at once, the arbiter uses round-robin priority.

Top module: `fifo_pair_sram_writer`

## Requirements
- R1: A synchronous active-high reset drives both read enables, the SRAM write strobe and the data output enable low on the following cycle. A write that is in flight when reset arrives never reaches the data bus.
- R2: When a source's empty flag is low at a rising edge and that source is eligible, its read enable is high for exactly the one cycle after that edge.
- R3: A read enable is never high for a source whose empty flag was high at the preceding rising edge. With both flags high, the block issues no read, no write strobe and no output enable.
- R4: A source is never read in the cycle immediately after its own read pulse. A FIFO holding one word therefore receives exactly one read.
- R5: At most one of the two read enables is high in any cycle.
- R6: In the cycle after a read pulse, `sram_we` is high and `sram_addr` equals the address word that the FIFO was presenting during the pulse. Each read produces exactly one write strobe.
- R7: The data word of a write appears on `sram_wdata`, with `sram_oe` high, exactly two cycles after the cycle in which its address and strobe are presented. `sram_oe` is low in every other cycle.
- R8: When both sources are eligible in the same cycle, the grant goes to the source that was not granted last. The first such contest after reset goes to source A.
- R9: With both FIFOs holding several words, grants alternate A, B, A, B. One SRAM write is issued every cycle, and each source's words keep their FIFO order.
- R10: With only one FIFO holding several words, that FIFO is read every second cycle, so one write is issued every second cycle, in FIFO order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | SRAM-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| a_empty | input | 1 | Source A empty flag, synchronised to clk |
| a_rd | output | 1 | Source A read enable (pop) |
| a_addr | input | ADDR_W | Source A head-word address |
| a_data | input | DATA_W | Source A head-word data |
| b_empty | input | 1 | Source B empty flag, synchronised to clk |
| b_rd | output | 1 | Source B read enable (pop) |
| b_addr | input | ADDR_W | Source B head-word address |
| b_data | input | DATA_W | Source B head-word data |
| sram_addr | output | ADDR_W | SRAM address, registered |
| sram_we | output | 1 | SRAM write strobe, active high |
| sram_wdata | output | DATA_W | SRAM write data, delayed by two cycles |
| sram_oe | output | 1 | Output enable for sram_wdata |

## Verification
The assertions assume first-word-fall-through FIFOs. They rely on a head word staying stable while its empty flag is low, and on the empty flag changing only after the clock edge that pops or fills the FIFO. The bench models each FIFO on exactly those terms. Words are pushed only at falling clock edges, each pop happens on the rising edge that samples a read enable, and the empty flag is derived from the FIFO model's pointers. Any read issued to an empty model is counted as an underflow and reported.

// File: rtl/arb_pkg.sv
package arb_pkg;

  localparam int NSRC = 2;

  typedef enum logic {
    SRC_A = 1'b0,
    SRC_B = 1'b1
  } src_e;

  function automatic logic [NSRC-1:0] src_onehot(input src_e s);
    logic [NSRC-1:0] v;
    v = '0;
    v[s] = 1'b1;
    return v;
  endfunction

  function automatic src_e src_other(input src_e s);
    return (s == SRC_A) ? SRC_B : SRC_A;
  endfunction

endpackage

// File: rtl/rr_picker.sv
module rr_picker
  import arb_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] empty_i,
  output logic [NSRC-1:0] pop_o,
  output logic            grant_vld_o,
  output src_e            grant_src_o
);

  logic [NSRC-1:0] pop_q;
  logic [NSRC-1:0] elig;
  src_e            last_q;
  src_e            src_q;
  src_e            pick;
  logic            any_elig;

  // A source that is popping this cycle still shows a stale low empty flag.
  assign elig     = ~empty_i & ~pop_q;
  assign any_elig = |elig;

  always_comb begin
    if (&elig)        pick = src_other(last_q);
    else if (elig[1]) pick = SRC_B;
    else              pick = SRC_A;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pop_q  <= '0;
      last_q <= SRC_B;
      src_q  <= SRC_A;
    end else begin
      pop_q <= any_elig ? src_onehot(pick) : '0;
      if (any_elig) begin
        src_q  <= pick;
        last_q <= pick;
      end
    end
  end

  assign pop_o       = pop_q;
  assign grant_vld_o = |pop_q;
  assign grant_src_o = src_q;

  // R5
  one_pop_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pop_q));

  // R8
  rr_turn_chk: assert property (@(posedge clk) disable iff (rst)
    (&elig) |=> (src_q != $past(last_q)));

  generate
    for (genvar k = 0; k < NSRC; k++) begin : g_src_chk
      // R3
      no_empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        pop_q[k] |-> $past(!empty_i[k]));
      // R4
      no_repop_chk: assert property (@(posedge clk) disable iff (rst)
        pop_q[k] |=> !pop_q[k]);
    end
  endgenerate

endmodule

// File: rtl/write_launch.sv
module write_launch
  import arb_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              grant_vld_i,
  input  src_e              grant_src_i,
  input  logic [ADDR_W-1:0] a_addr_i,
  input  logic [DATA_W-1:0] a_data_i,
  input  logic [ADDR_W-1:0] b_addr_i,
  input  logic [DATA_W-1:0] b_data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              we_o,
  output logic [DATA_W-1:0] data_o
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              we_q;

  // The popped word is the head the FIFO shows during the pop cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      we_q <= 1'b0;
    end else begin
      we_q <= grant_vld_i;
    end
  end

  always_ff @(posedge clk) begin
    if (grant_vld_i) begin
      addr_q <= (grant_src_i == SRC_B) ? b_addr_i : a_addr_i;
      data_q <= (grant_src_i == SRC_B) ? b_data_i : a_data_i;
    end
  end

  assign addr_o = addr_q;
  assign we_o   = we_q;
  assign data_o = data_q;

  // R6
  we_follows_pop_chk: assert property (@(posedge clk) disable iff (rst)
    grant_vld_i |=> we_q);

  // R6
  we_needs_pop_chk: assert property (@(posedge clk) disable iff (rst)
    we_q |-> $past(grant_vld_i));

endmodule

// File: rtl/data_delay.sv
module data_delay #(
  parameter int DATA_W = 16,
  parameter int LAG    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vld_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              vld_o,
  output logic [DATA_W-1:0] data_o
);

  logic [LAG-1:0]    v_q;
  logic [DATA_W-1:0] d_q [LAG];

  generate
    for (genvar i = 0; i < LAG; i++) begin : g_stage
      if (i == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (rst) v_q[0] <= 1'b0;
          else     v_q[0] <= vld_i;
        end
        always_ff @(posedge clk) begin
          if (vld_i) d_q[0] <= data_i;
        end
      end else begin : g_tail
        always_ff @(posedge clk) begin
          if (rst) v_q[i] <= 1'b0;
          else     v_q[i] <= v_q[i-1];
        end
        always_ff @(posedge clk) begin
          if (v_q[i-1]) d_q[i] <= d_q[i-1];
        end
      end
    end
  endgenerate

  assign vld_o  = v_q[LAG-1];
  assign data_o = d_q[LAG-1];

endmodule

// File: rtl/fifo_pair_sram_writer.sv
module fifo_pair_sram_writer
  import arb_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 16,
  parameter int DATA_LAG = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_empty,
  output logic              a_rd,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_data,
  input  logic              b_empty,
  output logic              b_rd,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_data,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_we,
  output logic [DATA_W-1:0] sram_wdata,
  output logic              sram_oe
);

  localparam int CNT_W = $clog2(DATA_LAG + 2) + 1;

  logic [NSRC-1:0]   pop;
  logic              grant_vld;
  src_e              grant_src;
  logic [DATA_W-1:0] launch_data;

  rr_picker u_pick (
    .clk         (clk),
    .rst         (rst),
    .empty_i     ({b_empty, a_empty}),
    .pop_o       (pop),
    .grant_vld_o (grant_vld),
    .grant_src_o (grant_src)
  );

  assign a_rd = pop[SRC_A];
  assign b_rd = pop[SRC_B];

  write_launch #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_launch (
    .clk         (clk),
    .rst         (rst),
    .grant_vld_i (grant_vld),
    .grant_src_i (grant_src),
    .a_addr_i    (a_addr),
    .a_data_i    (a_data),
    .b_addr_i    (b_addr),
    .b_data_i    (b_data),
    .addr_o      (sram_addr),
    .we_o        (sram_we),
    .data_o      (launch_data)
  );

  data_delay #(
    .DATA_W (DATA_W),
    .LAG    (DATA_LAG)
  ) u_delay (
    .clk    (clk),
    .rst    (rst),
    .vld_i  (sram_we),
    .data_i (launch_data),
    .vld_o  (sram_oe),
    .data_o (sram_wdata)
  );

  // Writes whose address has gone out but whose data has not yet.
  logic [CNT_W-1:0] inflight_q;
  always_ff @(posedge clk) begin
    if (rst) inflight_q <= '0;
    else     inflight_q <= inflight_q + CNT_W'(sram_we) - CNT_W'(sram_oe);
  end

  // R7
  inflight_bound_chk: assert property (@(posedge clk) disable iff (rst)
    inflight_q <= CNT_W'(DATA_LAG));

  // R7
  oe_has_addr_chk: assert property (@(posedge clk) disable iff (rst)
    sram_oe |-> (inflight_q != '0));

endmodule

// File: tb/sim_fifo_pair_sram_writer.sv
module sim_fifo_pair_sram_writer;

  localparam int AW = 10;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic a_empty, b_empty, a_rd, b_rd, sram_we, sram_oe;
  logic [AW-1:0] a_addr, b_addr, sram_addr;
  logic [DW-1:0] a_data, b_data, sram_wdata;

  fifo_pair_sram_writer u0 (
    .clk(clk), .rst(rst),
    .a_empty(a_empty), .a_rd(a_rd), .a_addr(a_addr), .a_data(a_data),
    .b_empty(b_empty), .b_rd(b_rd), .b_addr(b_addr), .b_data(b_data),
    .sram_addr(sram_addr), .sram_we(sram_we),
    .sram_wdata(sram_wdata), .sram_oe(sram_oe)
  );

  // First-word-fall-through FIFO models.
  logic [AW-1:0] amem_a [16];
  logic [DW-1:0] amem_d [16];
  logic [AW-1:0] bmem_a [16];
  logic [DW-1:0] bmem_d [16];
  int awp = 0, arp = 0, bwp = 0, brp = 0;
  int underflow = 0, a_pops = 0, b_pops = 0;

  assign a_empty = (awp == arp);
  assign b_empty = (bwp == brp);
  assign a_addr  = amem_a[arp % 16];
  assign a_data  = amem_d[arp % 16];
  assign b_addr  = bmem_a[brp % 16];
  assign b_data  = bmem_d[brp % 16];

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      arp <= 0; brp <= 0; underflow <= 0; a_pops <= 0; b_pops <= 0;
    end else begin
      if (a_rd) begin
        if (a_empty) underflow <= underflow + 1;
        else begin arp <= arp + 1; a_pops <= a_pops + 1; end
      end
      if (b_rd) begin
        if (b_empty) underflow <= underflow + 1;
        else begin brp <= brp + 1; b_pops <= b_pops + 1; end
      end
    end
  end

  // SRAM-side monitor, sampled away from the active edge.
  int wl_addr [64];
  int wl_cyc  [64];
  int dl_data [64];
  int dl_cyc  [64];
  int nw = 0, nd = 0;
  always @(negedge clk) begin
    if (sram_we && nw < 64) begin wl_addr[nw] = sram_addr; wl_cyc[nw] = cyc; nw++; end
    if (sram_oe && nd < 64) begin dl_data[nd] = sram_wdata; dl_cyc[nd] = cyc; nd++; end
  end

  int nchk = 0, nfail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int a_ad(input int i); return 'h040 + i; endfunction
  function automatic int a_dt(input int i); return 'hA000 + i; endfunction
  function automatic int b_ad(input int i); return 'h280 + i; endfunction
  function automatic int b_dt(input int i); return 'hB000 + i; endfunction

  task automatic push_a(input int n);
    for (int i = 0; i < n; i++) begin
      amem_a[awp % 16] = AW'(a_ad(i)); amem_d[awp % 16] = DW'(a_dt(i)); awp++;
    end
  endtask

  task automatic push_b(input int n);
    for (int i = 0; i < n; i++) begin
      bmem_a[bwp % 16] = AW'(b_ad(i)); bmem_d[bwp % 16] = DW'(b_dt(i)); bwp++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; awp = 0; bwp = 0;
    repeat (2) @(negedge clk);
    rst = 1'b0; nw = 0; nd = 0;
  endtask

  task automatic t_reset_state();
    do_reset();
    chk(!a_rd && !b_rd, "R1 rd after reset", {a_rd, b_rd}, 0);
    chk(!sram_we, "R1 we after reset", sram_we, 0);
    chk(!sram_oe, "R1 oe after reset", sram_oe, 0);
  endtask

  task automatic t_idle();
    int seen;
    do_reset();
    seen = 0;
    repeat (10) begin
      @(negedge clk);
      if (a_rd || b_rd || sram_we || sram_oe) seen++;
    end
    chk(seen == 0, "R3 idle activity", seen, 0);
  endtask

  task automatic t_single_a();
    do_reset();
    push_a(1);
    @(negedge clk);
    chk(a_rd && !b_rd, "R2 a_rd pulse", {a_rd, b_rd}, 2'b10);
    @(negedge clk);
    chk(!a_rd, "R4 no repeat read", a_rd, 0);
    chk(sram_we && sram_addr == AW'(a_ad(0)), "R6 addr cycle", sram_addr, a_ad(0));
    @(negedge clk);
    chk(!sram_we && !sram_oe && !a_rd, "R7 gap cycle", {sram_we, sram_oe, a_rd}, 0);
    @(negedge clk);
    chk(sram_oe && sram_wdata == DW'(a_dt(0)), "R7 data cycle", sram_wdata, a_dt(0));
    @(negedge clk);
    chk(!sram_oe, "R7 oe drops", sram_oe, 0);
    chk(a_pops == 1 && underflow == 0, "R4 one read for one word", a_pops, 1);
  endtask

  task automatic t_single_b();
    do_reset();
    push_b(1);
    @(negedge clk);
    chk(b_rd && !a_rd, "R2 b_rd pulse", {a_rd, b_rd}, 2'b01);
    @(negedge clk);
    chk(sram_we && sram_addr == AW'(b_ad(0)), "R6 b addr", sram_addr, b_ad(0));
    repeat (2) @(negedge clk);
    chk(sram_oe && sram_wdata == DW'(b_dt(0)), "R7 b data", sram_wdata, b_dt(0));
    chk(b_pops == 1 && underflow == 0, "R4 b one read", b_pops, 1);
  endtask

  task automatic t_contest();
    do_reset();
    push_a(1); push_b(1);
    @(negedge clk);
    chk(a_rd && !b_rd, "R8 first contest to A", {a_rd, b_rd}, 2'b10);
    @(negedge clk);
    chk(b_rd && !a_rd, "R5 B next alone", {a_rd, b_rd}, 2'b01);
    chk(sram_we && sram_addr == AW'(a_ad(0)), "R6 A addr", sram_addr, a_ad(0));
    @(negedge clk);
    chk(sram_we && sram_addr == AW'(b_ad(0)), "R9 B addr back to back", sram_addr, b_ad(0));
    @(negedge clk);
    chk(sram_oe && sram_wdata == DW'(a_dt(0)), "R7 A data", sram_wdata, a_dt(0));
    @(negedge clk);
    chk(sram_oe && sram_wdata == DW'(b_dt(0)), "R9 B data", sram_wdata, b_dt(0));
  endtask

  task automatic t_burst_a();
    do_reset();
    push_a(4);
    repeat (16) @(negedge clk);
    chk(nw == 4 && nd == 4, "R10 write count", nw, 4);
    for (int j = 0; j < 4; j++) begin
      chk(wl_addr[j] == a_ad(j), "R10 order", wl_addr[j], a_ad(j));
      chk(dl_data[j] == a_dt(j) && dl_cyc[j] == wl_cyc[j] + 2, "R7 burst data", dl_data[j], a_dt(j));
      if (j > 0) chk(wl_cyc[j] == wl_cyc[j-1] + 2, "R10 spacing", wl_cyc[j] - wl_cyc[j-1], 2);
    end
    chk(underflow == 0 && a_pops == 4, "R3 no underflow", underflow, 0);
  endtask

  task automatic t_burst_both();
    int ea, ed;
    do_reset();
    push_a(4); push_b(4);
    repeat (16) @(negedge clk);
    chk(nw == 8 && nd == 8, "R9 write count", nw, 8);
    for (int j = 0; j < 8; j++) begin
      ea = (j % 2 == 0) ? a_ad(j / 2) : b_ad(j / 2);
      ed = (j % 2 == 0) ? a_dt(j / 2) : b_dt(j / 2);
      chk(wl_addr[j] == ea, "R9 alternation", wl_addr[j], ea);
      chk(wl_cyc[j] == wl_cyc[0] + j, "R9 one per cycle", wl_cyc[j] - wl_cyc[0], j);
      chk(dl_data[j] == ed && dl_cyc[j] == wl_cyc[j] + 2, "R7 both data", dl_data[j], ed);
    end
    chk(underflow == 0, "R3 both no underflow", underflow, 0);
  endtask

  task automatic t_reset_flight();
    do_reset();
    push_a(1);
    repeat (2) @(negedge clk);
    chk(sram_we, "R6 we before abort", sram_we, 1);
    rst = 1'b1; awp = 0;
    @(negedge clk);
    chk(!sram_we && !a_rd, "R1 we cleared", sram_we, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!sram_oe, "R1 aborted data held off", sram_oe, 0);
    @(negedge clk);
    chk(!sram_oe, "R1 aborted data stays off", sram_oe, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_idle();
    t_single_a();
    t_single_b();
    t_contest();
    t_burst_a();
    t_burst_both();
    t_reset_flight();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

endmodule